// File: doc/BRIEF.md
# Dual-Bank Host Transfer Register File

This block is the CPU-facing register file of a host-side serial bus controller. It has two identical transfer descriptor banks and a handful of global registers, all reached over a byte-wide, byte-addressed read/write port. Each bank describes one transfer: an arm/control byte, a buffer base, a buffer length, a token/endpoint byte and a target device address. Two further read-only values come back from the transfer engine when that bank's transfer completes: a status byte and a count byte.

After reset the block runs in a compatibility mode where only bank A can start transfers. A single write of any value to offset 0Fh switches on extended mode, and only reset switches it off again. In extended mode the banks alternate. Firmware prepares one bank while the other one drives the engine, and each completion passes control to the other bank. If that bank is not yet armed, the block holds off until firmware arms it.

The block presents the active descriptor, which bank is active and whether that bank is armed. A completion strobe from the engine clears the arm bit, records status and count, and latches a per-bank done flag. The enabled done flags are ORed onto an interrupt line.

Top module: `hxf_regfile`

## Requirements
- R1: After reset, the control bytes of both banks and the registers at 05h, 07h, 0Dh, 0Eh and 0Fh all read 0, `act_valid` is 0, `act_bank` is 0 and `irq_o` is 0.
- R2: Bank A lies at offsets 00h–04h and bank B at 08h–0Ch (offset 0 control, 1 base, 2 length, 3 token/endpoint, 4 device address). Offsets 0–2 of each bank and the globals at 05h, 06h, 07h and 0Eh read back what was written. A read returns data on `cpu_rdata` one clock after the address is presented.
- R3: At bank offset 3, a write sets the token/endpoint byte (`act_pid`) and a read returns the engine status captured at that bank's last completion. At offset 4, a write sets the device address (`act_dev`) and a read returns the captured count.
- R4: A write of any data to 0Fh sets the extended-mode bit, which reads back in bit 0 of 0Fh. Only reset clears it.
- R5: While extended mode is clear, bank A stays active (`act_bank`=0) even after completions, and arming bank B never makes `act_valid` rise.
- R6: `act_valid` equals bit 0 (arm) of the active bank's control byte. A completion strobe while `act_valid` is 1 clears that bit. A strobe while `act_valid` is 0 is ignored: no bank change, no flag, no capture.
- R7: In extended mode, an accepted completion switches `act_bank` to the other bank. The active descriptor outputs then show that bank's registers.
- R8: If the bank taking over is not armed, `act_valid` stays 0 until firmware sets its arm bit, and then rises without any further completion.
- R9: Register 0Dh latches a done flag per bank (bit 0 bank A, bit 1 bank B). Writing 1 to a bit clears it. A completion in the same cycle as the clearing write leaves the flag set.
- R10: `irq_o` is 1 exactly when a done flag is set and its enable bit at 06h (bit 0 bank A, bit 1 bank B) is 1. It follows a flag or enable change one cycle after the write or the strobe.
- R11: Reads of offsets 10h and above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Register byte offset |
| cpu_wr | input | 1 | Write strobe for the current cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the address of the previous cycle |
| eng_done | input | 1 | One-cycle transfer completion strobe |
| eng_status | input | 8 | Transfer status captured on completion |
| eng_count | input | 8 | Transfer count captured on completion |
| act_valid | output | 1 | Active bank is armed, so the engine may start |
| act_bank | output | 1 | Active bank, 0 = A, 1 = B |
| act_ctrl | output | 8 | Active bank control byte |
| act_base | output | 8 | Active bank buffer base |
| act_len | output | 8 | Active bank buffer length |
| act_pid | output | 8 | Active bank token/endpoint byte |
| act_dev | output | 8 | Active bank device address |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench targets the offsets where reads and writes reach different storage. A design that shares that storage would return the token byte instead of the captured status. It arms bank B before extended mode is on and completes bank A, so a design that lets the second bank run early would switch banks or raise `act_valid`. It also lets a handover land on an unarmed bank and then sends a completion strobe that must be ignored, which catches a design that starts unarmed work or flips banks on every strobe. Finally it drives a completion and a write-one-to-clear of the same flag in one cycle, and writes to offsets above 0Fh, which catch a design with the wrong priority or an incomplete decode.

// File: rtl/hxf_pkg.sv
package hxf_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  localparam logic [2:0] SLOT_CTRL = 3'd0;
  localparam logic [2:0] SLOT_BASE = 3'd1;
  localparam logic [2:0] SLOT_LEN  = 3'd2;
  localparam logic [2:0] SLOT_PID  = 3'd3;
  localparam logic [2:0] SLOT_DEV  = 3'd4;
  localparam logic [2:0] SLOT_G0   = 3'd5;
  localparam logic [2:0] SLOT_G1   = 3'd6;
  localparam logic [2:0] SLOT_G2   = 3'd7;
  localparam int NUM_BANKS = 2;
  localparam int DESC_SLOTS = 4;
endpackage

// File: rtl/hxf_bank.sv
module hxf_bank
  import hxf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    slot,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          done_i,
  input  logic [DW-1:0] eng_status,
  input  logic [DW-1:0] eng_count,
  output logic          arm_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] len_o,
  output logic [DW-1:0] pid_o,
  output logic [DW-1:0] dev_o
);
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] desc_mem [DESC_SLOTS];
  logic [DW-1:0] xstat_q;
  logic [DW-1:0] xcnt_q;
  logic          desc_we;
  logic [1:0]    desc_idx;

  assign desc_we  = wr_en && (slot != SLOT_CTRL);
  assign desc_idx = 2'(slot - 3'd1);

  // descriptor storage: no reset, plain array write
  always_ff @(posedge clk) begin
    if (desc_we) desc_mem[desc_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (done_i) ctrl_q[0] <= 1'b0;
      if (wr_en && slot == SLOT_CTRL) ctrl_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (done_i) begin
      xstat_q <= eng_status;
      xcnt_q  <= eng_count;
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_CTRL: rd_data = ctrl_q;
      SLOT_BASE: rd_data = desc_mem[0];
      SLOT_LEN:  rd_data = desc_mem[1];
      SLOT_PID:  rd_data = xstat_q;
      SLOT_DEV:  rd_data = xcnt_q;
      default:   rd_data = '0;
    endcase
  end

  assign arm_o  = ctrl_q[0];
  assign ctrl_o = ctrl_q;
  assign base_o = desc_mem[0];
  assign len_o  = desc_mem[1];
  assign pid_o  = desc_mem[2];
  assign dev_o  = desc_mem[3];

  // R6: an accepted completion drops the arm bit unless firmware rewrites it
  assert_arm_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (done_i && !(wr_en && slot == SLOT_CTRL)) |=> !ctrl_q[0]);
endmodule

// File: rtl/hxf_seq.sv
module hxf_seq
  import hxf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ext_set,
  input  logic  done_i,
  input  logic  arm_a,
  input  logic  arm_b,
  output logic  ext_o,
  output bank_e cur_o,
  output logic  valid_o,
  output logic  done_a_o,
  output logic  done_b_o
);
  logic  ext_q;
  bank_e cur_q;
  logic  accept;

  assign valid_o  = (cur_q == BANK_B) ? arm_b : arm_a;
  assign accept   = done_i && valid_o;
  assign done_a_o = accept && (cur_q == BANK_A);
  assign done_b_o = accept && (cur_q == BANK_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b0;
      cur_q <= BANK_A;
    end else begin
      if (ext_set) ext_q <= 1'b1;
      if (accept && ext_q) cur_q <= (cur_q == BANK_A) ? BANK_B : BANK_A;
    end
  end

  assign ext_o = ext_q;
  assign cur_o = cur_q;

  // R4: the extended-mode latch never falls outside reset
  assert_ext_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ext_q |=> ext_q);
  // R7: accepted completion in extended mode hands over to the other bank
  assert_handover_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && ext_q) |=> (cur_q != $past(cur_q)));
  // R5: compatibility mode keeps bank A in charge
  assert_compat_bank_a_R5: assert property (@(posedge clk) disable iff (rst)
    !ext_q |-> (cur_q == BANK_A));
  // R6: a strobe with nothing armed leaves the active bank alone
  assert_ignore_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (done_i && !valid_o) |=> $stable(cur_q));
endmodule

// File: rtl/hxf_irq.sv
module hxf_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic          clr_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          set_a,
  input  logic          set_b,
  output logic [DW-1:0] en_o,
  output logic [1:0]    flags_o,
  output logic          irq_o
);
  logic [DW-1:0] en_q, en_d;
  logic [1:0]    flags_q, flags_d;
  logic          irq_q;

  always_comb begin
    en_d    = en_wr ? wr_data : en_q;
    flags_d = flags_q;
    if (clr_wr) flags_d = flags_d & ~wr_data[1:0];
    if (set_a)  flags_d[0] = 1'b1;
    if (set_b)  flags_d[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      flags_q <= flags_d;
      irq_q   <= |(flags_d & en_d[1:0]);
    end
  end

  assign en_o    = en_q;
  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  // R9: a completion always leaves its flag set, even against a clear
  assert_flag_set_a_R9: assert property (@(posedge clk) disable iff (rst)
    set_a |=> flags_q[0]);
  assert_flag_set_b_R9: assert property (@(posedge clk) disable iff (rst)
    set_b |=> flags_q[1]);
  // R10: interrupt only with an enabled latched flag
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> |(flags_q & en_q[1:0]));
endmodule

// File: rtl/hxf_regfile.sv
module hxf_regfile
  import hxf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_status,
  input  logic [DW-1:0] eng_count,
  output logic          act_valid,
  output logic          act_bank,
  output logic [DW-1:0] act_ctrl,
  output logic [DW-1:0] act_base,
  output logic [DW-1:0] act_len,
  output logic [DW-1:0] act_pid,
  output logic [DW-1:0] act_dev,
  output logic          irq_o
);
  localparam int HI_W = AW - 4;

  logic          in_window;
  logic          hi_half;
  logic [2:0]    slot;
  logic          is_global;

  assign in_window = (cpu_addr[AW-1:4] == HI_W'(0));
  assign hi_half   = cpu_addr[3];
  assign slot      = cpu_addr[2:0];
  assign is_global = in_window && (slot >= SLOT_G0);

  logic [DW-1:0] b_rd   [NUM_BANKS];
  logic [DW-1:0] b_ctrl [NUM_BANKS];
  logic [DW-1:0] b_base [NUM_BANKS];
  logic [DW-1:0] b_len  [NUM_BANKS];
  logic [DW-1:0] b_pid  [NUM_BANKS];
  logic [DW-1:0] b_dev  [NUM_BANKS];
  logic          b_arm  [NUM_BANKS];
  logic          b_done [NUM_BANKS];

  logic  ext_q;
  bank_e cur;
  logic  valid_w, done_a, done_b;

  assign b_done[0] = done_a;
  assign b_done[1] = done_b;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic bank_we;
    assign bank_we = cpu_wr && in_window && (hi_half == 1'(g)) && (slot <= SLOT_DEV);
    hxf_bank #(.DW(DW)) bank_i (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (bank_we),
      .slot       (slot),
      .wr_data    (cpu_wdata),
      .rd_data    (b_rd[g]),
      .done_i     (b_done[g]),
      .eng_status (eng_status),
      .eng_count  (eng_count),
      .arm_o      (b_arm[g]),
      .ctrl_o     (b_ctrl[g]),
      .base_o     (b_base[g]),
      .len_o      (b_len[g]),
      .pid_o      (b_pid[g]),
      .dev_o      (b_dev[g])
    );
  end

  hxf_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .ext_set  (cpu_wr && is_global && hi_half && slot == SLOT_G2),
    .done_i   (eng_done),
    .arm_a    (b_arm[0]),
    .arm_b    (b_arm[1]),
    .ext_o    (ext_q),
    .cur_o    (cur),
    .valid_o  (valid_w),
    .done_a_o (done_a),
    .done_b_o (done_b)
  );

  logic [DW-1:0] irq_en;
  logic [1:0]    flags;

  hxf_irq #(.DW(DW)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .en_wr   (cpu_wr && is_global && !hi_half && slot == SLOT_G1),
    .clr_wr  (cpu_wr && is_global && hi_half && slot == SLOT_G0),
    .wr_data (cpu_wdata),
    .set_a   (done_a),
    .set_b   (done_b),
    .en_o    (irq_en),
    .flags_o (flags),
    .irq_o   (irq_o)
  );

  // plain global registers: 05h, 07h, 0Eh
  logic [DW-1:0] mode_q, peer_q, aux_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      peer_q <= '0;
      aux_q  <= '0;
    end else if (cpu_wr && is_global) begin
      if (!hi_half && slot == SLOT_G0) mode_q <= cpu_wdata;
      if (!hi_half && slot == SLOT_G2) peer_q <= cpu_wdata;
      if ( hi_half && slot == SLOT_G1) aux_q  <= cpu_wdata;
    end
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (in_window) begin
      if (slot <= SLOT_DEV) begin
        rd_next = b_rd[hi_half];
      end else begin
        unique case ({hi_half, slot})
          {1'b0, SLOT_G0}: rd_next = mode_q;
          {1'b0, SLOT_G1}: rd_next = irq_en;
          {1'b0, SLOT_G2}: rd_next = peer_q;
          {1'b1, SLOT_G0}: rd_next = DW'(flags);
          {1'b1, SLOT_G1}: rd_next = aux_q;
          {1'b1, SLOT_G2}: rd_next = DW'(ext_q);
          default:         rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_next;
  end

  assign act_valid = valid_w;
  assign act_bank  = cur;
  assign act_ctrl  = b_ctrl[cur];
  assign act_base  = b_base[cur];
  assign act_len   = b_len[cur];
  assign act_pid   = b_pid[cur];
  assign act_dev   = b_dev[cur];

  // R11: the window above 0Fh reads as zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !in_window |=> (cpu_rdata == '0));
  // R8: an unarmed active bank never reports valid
  assert_no_unarmed_start_R8: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> act_ctrl[0]);
endmodule

// File: tb/hxf_regfile_tb_top.sv
module hxf_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] cpu_addr;
  logic       cpu_wr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       eng_done;
  logic [7:0] eng_status, eng_count;
  logic       act_valid, act_bank, irq_o;
  logic [7:0] act_ctrl, act_base, act_len, act_pid, act_dev;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hxf_regfile dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_done(eng_done),
    .eng_status(eng_status), .eng_count(eng_count), .act_valid(act_valid),
    .act_bank(act_bank), .act_ctrl(act_ctrl), .act_base(act_base),
    .act_len(act_len), .act_pid(act_pid), .act_dev(act_dev), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cpu_addr = a;
    @(negedge clk);
    check(req, $sformatf("read %02h", a), cpu_rdata, exp);
  endtask

  task automatic done_pulse(input logic [7:0] st, input logic [7:0] cnt);
    eng_status = st; eng_count = cnt; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "act_valid", act_valid, 0);
    check("R1", "act_bank", act_bank, 0);
    check("R1", "irq_o", irq_o, 0);
    rd_chk("R1", 8'h00, 8'h00);
    rd_chk("R1", 8'h08, 8'h00);
    rd_chk("R1", 8'h05, 8'h00);
    rd_chk("R1", 8'h07, 8'h00);
    rd_chk("R1", 8'h0D, 8'h00);
    rd_chk("R1", 8'h0E, 8'h00);
    rd_chk("R1", 8'h0F, 8'h00);
  endtask

  task automatic t_regmap;
    wr(8'h01, 8'h11); wr(8'h02, 8'h22);
    wr(8'h09, 8'h99); wr(8'h0A, 8'hAA);
    wr(8'h05, 8'h5A); wr(8'h07, 8'h77); wr(8'h0E, 8'hE3);
    wr(8'h06, 8'h00);
    rd_chk("R2", 8'h01, 8'h11);
    rd_chk("R2", 8'h02, 8'h22);
    rd_chk("R2", 8'h09, 8'h99);
    rd_chk("R2", 8'h0A, 8'hAA);
    rd_chk("R2", 8'h05, 8'h5A);
    rd_chk("R2", 8'h07, 8'h77);
    rd_chk("R2", 8'h0E, 8'hE3);
    check("R2", "act_base bank A", act_base, 8'h11);
    check("R2", "act_len bank A", act_len, 8'h22);
  endtask

  task automatic t_split;
    wr(8'h03, 8'h69); wr(8'h04, 8'h05);
    wr(8'h0B, 8'h2D); wr(8'h0C, 8'h0B);
    check("R3", "act_pid", act_pid, 8'h69);
    check("R3", "act_dev", act_dev, 8'h05);
    wr(8'h00, 8'h81);
    check("R6", "act_valid armed", act_valid, 1);
    check("R6", "act_ctrl", act_ctrl, 8'h81);
    done_pulse(8'hC3, 8'h12);
    check("R6", "act_valid after done", act_valid, 0);
    rd_chk("R6", 8'h00, 8'h80);
    rd_chk("R3", 8'h03, 8'hC3);
    rd_chk("R3", 8'h04, 8'h12);
    check("R3", "act_pid kept", act_pid, 8'h69);
  endtask

  task automatic t_compat;
    wr(8'h08, 8'h01);
    check("R5", "act_valid B armed compat", act_valid, 0);
    check("R5", "act_bank", act_bank, 0);
    wr(8'h00, 8'h01);
    done_pulse(8'h01, 8'h02);
    check("R5", "act_bank after done", act_bank, 0);
    check("R5", "act_valid after done", act_valid, 0);
    rd_chk("R5", 8'h08, 8'h01);
  endtask

  task automatic t_irq;
    rd_chk("R9", 8'h0D, 8'h01);
    check("R10", "irq disabled", irq_o, 0);
    wr(8'h06, 8'h01);
    check("R10", "irq enabled", irq_o, 1);
    wr(8'h0D, 8'h01);
    check("R10", "irq after clear", irq_o, 0);
    rd_chk("R9", 8'h0D, 8'h00);
    wr(8'h00, 8'h01);
    cpu_addr = 8'h0D; cpu_wdata = 8'h01; cpu_wr = 1'b1;
    eng_status = 8'h00; eng_count = 8'h00; eng_done = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; eng_done = 1'b0;
    rd_chk("R9", 8'h0D, 8'h01);
    check("R10", "irq set wins", irq_o, 1);
    wr(8'h0D, 8'h01);
  endtask

  task automatic t_ext;
    wr(8'h0F, 8'h00);
    rd_chk("R4", 8'h0F, 8'h01);
    wr(8'h0F, 8'hFF);
    rd_chk("R4", 8'h0F, 8'h01);
  endtask

  task automatic t_pingpong;
    wr(8'h00, 8'h01);
    check("R7", "start on A", act_bank, 0);
    done_pulse(8'h00, 8'h00);
    check("R7", "handover to B", act_bank, 1);
    check("R7", "B armed valid", act_valid, 1);
    check("R7", "B base visible", act_base, 8'h99);
    check("R7", "B pid visible", act_pid, 8'h2D);
    done_pulse(8'h00, 8'h00);
    check("R7", "back to A", act_bank, 0);
    check("R8", "A unarmed waits", act_valid, 0);
    rd_chk("R9", 8'h0D, 8'h03);
    wr(8'h0D, 8'h03);
    done_pulse(8'h00, 8'h00);
    check("R6", "idle strobe bank", act_bank, 0);
    rd_chk("R6", 8'h0D, 8'h00);
    repeat (3) @(negedge clk);
    check("R8", "still waiting", act_valid, 0);
    wr(8'h00, 8'h01);
    check("R8", "starts once armed", act_valid, 1);
    check("R8", "bank A", act_bank, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h10, 8'hFF);
    wr(8'h40, 8'h00);
    wr(8'hF0, 8'h07);
    rd_chk("R11", 8'h10, 8'h00);
    rd_chk("R11", 8'hFF, 8'h00);
    rd_chk("R11", 8'h00, 8'h01);
    rd_chk("R11", 8'h05, 8'h5A);
    rd_chk("R11", 8'h0D, 8'h00);
    check("R11", "act_valid kept", act_valid, 1);
  endtask

  task automatic t_reset_clears_ext;
    do_reset();
    rd_chk("R4", 8'h0F, 8'h00);
    check("R1", "act_valid after reset", act_valid, 0);
    rd_chk("R1", 8'h00, 8'h00);
  endtask

  initial begin
    cpu_addr = '0; cpu_wr = 1'b0; cpu_wdata = '0;
    eng_done = 1'b0; eng_status = '0; eng_count = '0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_regmap();
    t_split();
    t_compat();
    t_irq();
    t_ext();
    t_pingpong();
    t_unmapped();
    t_reset_clears_ext();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule